// File: doc/BRIEF.md
# Single-Edge Nibble Frame Transmitter

This block turns a status value and two 12-bit measurement words into one serial frame in which every value is carried as the time between two falling edges of a single output line. A tick-enable input sets the time base. Each frame opens with a fixed-length calibration pulse, and each later interval stretches by the value it carries. The timing counters only move on cycles where the tick enable is high, so the line rate is set entirely by how often the surrounding logic pulses that input.

A frame starts on a start strobe. It then sends the status nibble, six data nibbles and a computed checksum nibble. A closing falling edge ends the last interval. A raw mode can also be chosen at start. In raw mode, eight caller-supplied nibbles go out exactly as given, with no formatting and no checksum. A busy flag covers the whole frame. Start requests that arrive while the flag is up are dropped.

Top module: `sent_tx`

## Requirements
- R1: After reset and between frames, `line_o` is high and `busy_o` is low.
- R2: The first interval of a frame lasts 56 ticks from the falling edge at frame start to the next falling edge, and its low portion lasts 5 ticks.
- R3: Each nibble interval lasts 12 + v ticks (v = nibble value 0..15), measured between falling edges, and its low portion lasts 5 ticks.
- R4: Nibble order after the calibration interval is as follows. Position 0 is the status nibble. Positions 1..3 are `data_a_i` bits [11:8], [7:4], [3:0]. Positions 4..6 are the same slices of `data_b_i`. Position 7 is the checksum. A frame therefore has exactly 10 falling edges.
- R5: In formatted mode the checksum is a CRC-4 with generator x^4+x^3+x^2+1 and initial value 4'b0101. It is computed over the six data nibbles only (the status nibble is excluded), followed by one all-zero nibble of augmentation.
- R6: When `raw_en_i` is high at an accepted start, nibble k of the frame is `raw_nibs_i[4k+3:4k]` for k = 0..7, sent unchanged.
- R7: After the checksum interval, one more falling edge is produced. The line stays low for 5 ticks, then returns high, and `busy_o` falls on that same clock edge.
- R8: A start strobe seen with `busy_o` low is accepted whatever the value of `tick_i`. In the next cycle `busy_o` is high and `line_o` is low.
- R9: A start strobe while busy is ignored. Input values are captured only at acceptance, so changing them during a frame has no effect on it.
- R10: The frame advances only on clock edges where `tick_i` is high. With `tick_i` low, the line holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Unit-time enable |
| start_i | input | 1 | Frame request strobe |
| status_i | input | 4 | Status nibble |
| data_a_i | input | 12 | First data word |
| data_b_i | input | 12 | Second data word |
| raw_en_i | input | 1 | Send raw nibbles instead of formatted frame |
| raw_nibs_i | input | 32 | Eight raw nibbles, nibble k at bits [4k+3:4k] |
| line_o | output | 1 | Serial line level |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default parameters: 12-bit words, a 5-tick low portion, a 56-tick calibration interval and a 12-tick nibble offset. With these values the shortest and longest nibble intervals, 12 and 27 ticks, appear with all-zero and all-ones data. The tick enable is driven with random densities from sparse to every cycle, which exercises holds of many idle cycles between ticks as well as back-to-back ticks.

// File: rtl/sent_tx_pkg.sv
package sent_tx_pkg;

  localparam int NIB_W = 4;

  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic [1:0] {
    SEG_CAL   = 2'd0,
    SEG_VALUE = 2'd1,
    SEG_CLOSE = 2'd2
  } seg_kind_e;

  // Shift one nibble, MSB first, through a 4-bit CRC register.
  // poly_low holds the generator without its x^4 term.
  function automatic nib_t crc4_shift(input nib_t crc, input nib_t nib, input nib_t poly_low);
    nib_t r;
    logic fb;
    r = crc;
    for (int b = NIB_W - 1; b >= 0; b--) begin
      fb = r[NIB_W-1];
      r  = {r[NIB_W-2:0], nib[b]};
      if (fb) r = r ^ poly_low;
    end
    return r;
  endfunction

  // Interval length in ticks for a nibble value.
  function automatic int unsigned value_ticks(input nib_t v, input int unsigned offset);
    return offset + int'(v);
  endfunction

endpackage

// File: rtl/sent_tx_frame_build.sv
module sent_tx_frame_build
  import sent_tx_pkg::*;
#(
  parameter int   WORD_W    = 12,
  parameter int   NUM_WORDS = 2,
  parameter nib_t CRC_SEED  = 4'h5,
  parameter nib_t CRC_POLY  = 4'hD,
  localparam int  NIB_PER_WORD = WORD_W / NIB_W,
  localparam int  DATA_NIB     = NUM_WORDS * NIB_PER_WORD,
  localparam int  FRAME_NIB    = DATA_NIB + 2
) (
  input  nib_t                          status_i,
  input  logic [NUM_WORDS*WORD_W-1:0]   words_i,
  input  logic                          raw_en_i,
  input  logic [FRAME_NIB*NIB_W-1:0]    raw_i,
  output logic [FRAME_NIB*NIB_W-1:0]    frame_o
);

  nib_t                       data_nib [DATA_NIB];
  nib_t                       crc_val;
  logic [FRAME_NIB*NIB_W-1:0] formatted;

  // Split each word, most significant nibble first.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar n = 0; n < NIB_PER_WORD; n++) begin : g_nib
      assign data_nib[w*NIB_PER_WORD + n] =
        words_i[w*WORD_W + (NIB_PER_WORD-1-n)*NIB_W +: NIB_W];
    end
  end

  always_comb begin
    crc_val = CRC_SEED;
    for (int i = 0; i < DATA_NIB; i++) begin
      crc_val = crc4_shift(crc_val, data_nib[i], CRC_POLY);
    end
    crc_val = crc4_shift(crc_val, '0, CRC_POLY);
  end

  always_comb begin
    formatted = '0;
    formatted[0 +: NIB_W] = status_i;
    for (int i = 0; i < DATA_NIB; i++) begin
      formatted[(i+1)*NIB_W +: NIB_W] = data_nib[i];
    end
    formatted[(FRAME_NIB-1)*NIB_W +: NIB_W] = crc_val;
  end

  assign frame_o = raw_en_i ? raw_i : formatted;

endmodule

// File: rtl/sent_tx_timer.sv
module sent_tx_timer
  import sent_tx_pkg::*;
#(
  parameter int  LOW_TICKS  = 5,
  parameter int  SYNC_TICKS = 56,
  parameter int  NIB_OFFSET = 12,
  parameter int  FRAME_NIB  = 8,
  localparam int MAX_VAL_LEN = NIB_OFFSET + (1 << NIB_W) - 1,
  localparam int MAX_LEN     = (SYNC_TICKS > MAX_VAL_LEN) ? SYNC_TICKS : MAX_VAL_LEN,
  localparam int CNT_W       = $clog2(MAX_LEN + 1),
  localparam int SEG_W       = $clog2(FRAME_NIB + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             accept_i,
  input  nib_t             cur_nib_i,
  output logic             busy_o,
  output logic [SEG_W-1:0] seg_o,
  output logic [CNT_W-1:0] pos_o,
  output logic             seg_end_o,
  output seg_kind_e        kind_o
);

  localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(FRAME_NIB + 1);

  logic [CNT_W-1:0] seg_len;

  always_comb begin
    if (seg_o == '0)           kind_o = SEG_CAL;
    else if (seg_o == SEG_LAST) kind_o = SEG_CLOSE;
    else                        kind_o = SEG_VALUE;
  end

  always_comb begin
    case (kind_o)
      SEG_CAL:   seg_len = CNT_W'(SYNC_TICKS);
      SEG_CLOSE: seg_len = CNT_W'(LOW_TICKS);
      default:   seg_len = CNT_W'(value_ticks(cur_nib_i, NIB_OFFSET));
    endcase
  end

  assign seg_end_o = (pos_o == seg_len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      seg_o  <= '0;
      pos_o  <= '0;
    end else if (accept_i && !busy_o) begin
      busy_o <= 1'b1;
      seg_o  <= '0;
      pos_o  <= '0;
    end else if (busy_o && tick_i) begin
      if (seg_end_o) begin
        pos_o <= '0;
        if (kind_o == SEG_CLOSE) begin
          busy_o <= 1'b0;
          seg_o  <= '0;
        end else begin
          seg_o <= seg_o + 1'b1;
        end
      end else begin
        pos_o <= pos_o + 1'b1;
      end
    end
  end

  p_hold_no_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> ($stable(pos_o) && $stable(seg_o)));

  p_accept_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !busy_o) |=> (busy_o && seg_o == '0 && pos_o == '0));

  p_seg_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i && seg_end_o && kind_o != SEG_CLOSE) |=>
      (busy_o && pos_o == '0 && seg_o == $past(seg_o) + 1'b1));

  p_pos_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (pos_o < seg_len));

endmodule

// File: rtl/sent_tx_shaper.sv
module sent_tx_shaper #(
  parameter int LOW_TICKS = 5,
  parameter int CNT_W     = 6
) (
  input  logic             busy_i,
  input  logic [CNT_W-1:0] pos_i,
  output logic             line_o
);

  // Every interval opens with a fixed low portion; the rest is high.
  always_comb begin
    line_o = !(busy_i && (pos_i < CNT_W'(LOW_TICKS)));
  end

endmodule

// File: rtl/sent_tx.sv
module sent_tx
  import sent_tx_pkg::*;
#(
  parameter int   WORD_W     = 12,
  parameter int   LOW_TICKS  = 5,
  parameter int   SYNC_TICKS = 56,
  parameter int   NIB_OFFSET = 12,
  parameter nib_t CRC_SEED   = 4'h5,
  parameter nib_t CRC_POLY   = 4'hD,
  localparam int  NUM_WORDS  = 2,
  localparam int  FRAME_NIB  = NUM_WORDS * (WORD_W / NIB_W) + 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic                       start_i,
  input  logic [NIB_W-1:0]           status_i,
  input  logic [WORD_W-1:0]          data_a_i,
  input  logic [WORD_W-1:0]          data_b_i,
  input  logic                       raw_en_i,
  input  logic [FRAME_NIB*NIB_W-1:0] raw_nibs_i,
  output logic                       line_o,
  output logic                       busy_o
);

  localparam int MAX_VAL_LEN = NIB_OFFSET + (1 << NIB_W) - 1;
  localparam int MAX_LEN     = (SYNC_TICKS > MAX_VAL_LEN) ? SYNC_TICKS : MAX_VAL_LEN;
  localparam int CNT_W       = $clog2(MAX_LEN + 1);
  localparam int SEG_W       = $clog2(FRAME_NIB + 2);

  logic [FRAME_NIB*NIB_W-1:0] frame_next;
  logic [FRAME_NIB*NIB_W-1:0] frame_q;
  logic                       accept;
  nib_t                       cur_nib;
  logic [SEG_W-1:0]           seg;
  logic [CNT_W-1:0]           pos;
  logic                       seg_end;
  seg_kind_e                  kind;

  assign accept = start_i && !busy_o;

  sent_tx_frame_build #(
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS),
    .CRC_SEED (CRC_SEED),
    .CRC_POLY (CRC_POLY)
  ) u_build (
    .status_i(status_i),
    .words_i ({data_b_i, data_a_i}),
    .raw_en_i(raw_en_i),
    .raw_i   (raw_nibs_i),
    .frame_o (frame_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_q <= '0;
    else if (accept) frame_q <= frame_next;
  end

  // Segment k+1 carries frame nibble k.
  always_comb begin
    cur_nib = '0;
    for (int k = 0; k < FRAME_NIB; k++) begin
      if (seg == SEG_W'(k + 1)) cur_nib = frame_q[k*NIB_W +: NIB_W];
    end
  end

  sent_tx_timer #(
    .LOW_TICKS (LOW_TICKS),
    .SYNC_TICKS(SYNC_TICKS),
    .NIB_OFFSET(NIB_OFFSET),
    .FRAME_NIB (FRAME_NIB)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .accept_i (accept),
    .cur_nib_i(cur_nib),
    .busy_o   (busy_o),
    .seg_o    (seg),
    .pos_o    (pos),
    .seg_end_o(seg_end),
    .kind_o   (kind)
  );

  sent_tx_shaper #(
    .LOW_TICKS(LOW_TICKS),
    .CNT_W    (CNT_W)
  ) u_shaper (
    .busy_i(busy_o),
    .pos_i (pos),
    .line_o(line_o)
  );

  p_frame_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(frame_q)));

  p_quiet_without_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> $stable(line_o));

  p_accept_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (busy_o && !line_o));

  p_release_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> line_o);

  p_close_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i && seg_end && kind == SEG_CLOSE) |=> (!busy_o && line_o));

endmodule

// File: tb/sent_tx_bench.sv
module sent_tx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  status = '0;
  logic [11:0] data_a = '0;
  logic [11:0] data_b = '0;
  logic        raw_en = 1'b0;
  logic [31:0] raw = '0;
  logic        line_out;
  logic        busy;

  always #5 clk = ~clk;

  sent_tx u_sent_tx (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .start_i   (start),
    .status_i  (status),
    .data_a_i  (data_a),
    .data_b_i  (data_b),
    .raw_en_i  (raw_en),
    .raw_nibs_i(raw),
    .line_o    (line_out),
    .busy_o    (busy)
  );

  int   tests = 0;
  int   fails = 0;
  int   tick_pct = 100;
  bit   mon_on = 1'b0;
  int   tcnt = 0;
  int   nfall = 0;
  int   ivl [10];
  int   lowt [10];
  logic prev_line = 1'b1;

  // Monitor: counts ticks between falling edges and low widths.
  always @(negedge clk) begin
    if (mon_on) begin
      tcnt = tcnt + int'(tick);
      if (prev_line && !line_out) begin
        if (nfall >= 1 && nfall <= 9) ivl[nfall] = tcnt;
        nfall = nfall + 1;
        tcnt  = 0;
      end else if (!prev_line && line_out) begin
        if (nfall >= 1 && nfall <= 10) lowt[nfall-1] = tcnt;
      end
    end
    prev_line = line_out;
    tick = ($urandom_range(99) < tick_pct);
  end

  task automatic chk_eq(input string req, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // x * x^4 mod (x^4+x^3+x^2+1) by long division
  function automatic int mul_x4(input int x);
    int r;
    r = x << 4;
    for (int b = 7; b >= 4; b--) begin
      if ((r & (1 << b)) != 0) r = r ^ (32'h1D << (b - 4));
    end
    return r & 15;
  endfunction

  function automatic int exp_crc(input logic [11:0] a, input logic [11:0] b);
    int c;
    int d [6];
    d[0] = int'(a[11:8]); d[1] = int'(a[7:4]); d[2] = int'(a[3:0]);
    d[3] = int'(b[11:8]); d[4] = int'(b[7:4]); d[5] = int'(b[3:0]);
    c = 5;
    for (int i = 0; i < 6; i++) c = mul_x4(c) ^ d[i];
    return mul_x4(c);
  endfunction

  task automatic send_frame(input logic [3:0] st, input logic [11:0] a, input logic [11:0] b,
                            input bit ovr, input logic [31:0] rw, input int pct,
                            input bit disturb, input string tag);
    int expn [8];
    int guard;
    int total;
    int exp_total;
    string ctag;
    if (ovr) begin
      for (int k = 0; k < 8; k++) expn[k] = int'(rw[4*k +: 4]);
    end else begin
      expn[0] = int'(st);
      expn[1] = int'(a[11:8]); expn[2] = int'(a[7:4]); expn[3] = int'(a[3:0]);
      expn[4] = int'(b[11:8]); expn[5] = int'(b[7:4]); expn[6] = int'(b[3:0]);
      expn[7] = exp_crc(a, b);
    end
    tick_pct = pct;
    @(negedge clk);
    status = st; data_a = a; data_b = b; raw_en = ovr; raw = rw;
    nfall = 0; tcnt = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_eq("R8", "busy after start", int'(busy), 1);
    chk_eq("R8", "line after start", int'(line_out), 0);
    if (disturb) begin
      repeat (40) @(negedge clk);
      status = ~st; data_a = ~a; data_b = b ^ 12'h5A5; raw_en = ~ovr; raw = ~rw;
      start = 1'b1;
      repeat (30) @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (busy && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    chk_eq("R7", "busy after frame", int'(busy), 0);
    chk_eq("R1", "idle line level", int'(line_out), 1);
    chk_eq("R4", "falling edge count", nfall, 10);
    chk_eq("R2", "calibration interval", ivl[1], 56);
    chk_eq("R2", "calibration low ticks", lowt[0], 5);
    for (int k = 0; k < 8; k++) begin
      chk_eq("R3", $sformatf("nibble %0d interval", k), ivl[k+2], 12 + expn[k]);
      chk_eq("R3", $sformatf("nibble %0d low ticks", k), lowt[k+1], 5);
    end
    chk_eq("R4", "status position value", ivl[2] - 12, expn[0]);
    ctag = ovr ? "R6" : "R5";
    chk_eq(ctag, "checksum nibble", ivl[9] - 12, expn[7]);
    chk_eq("R7", "closing low ticks", lowt[9], 5);
    total = 0;
    exp_total = 56;
    for (int k = 1; k <= 9; k++) total += ivl[k];
    for (int k = 0; k < 8; k++) exp_total += 12 + expn[k];
    chk_eq(tag, "frame tick total", total, exp_total);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1", "busy after reset", int'(busy), 0);
    chk_eq("R1", "line after reset", int'(line_out), 1);
    mon_on = 1'b1;
    // A quiet stretch with ticks leaves the idle line alone.
    repeat (20) @(negedge clk);
    chk_eq("R1", "idle line with ticks", int'(line_out), 1);

    // Directed corners.
    send_frame(4'h0, 12'h000, 12'h000, 1'b0, 32'h0, 100, 1'b0, "R3");
    send_frame(4'hF, 12'hFFF, 12'hFFF, 1'b0, 32'h0, 100, 1'b0, "R3");
    send_frame(4'h3, 12'h123, 12'hABC, 1'b0, 32'h0, 100, 1'b0, "R4");
    send_frame(4'h9, 12'h5A0, 12'h0F3, 1'b0, 32'h0, 10, 1'b0, "R10");
    send_frame(4'h1, 12'hDEF, 12'h000, 1'b1, 32'hFFFF_FFFF, 100, 1'b0, "R6");
    send_frame(4'h1, 12'hDEF, 12'h000, 1'b1, 32'h0000_0000, 60, 1'b0, "R6");
    send_frame(4'h2, 12'h777, 12'h888, 1'b1, 32'h7E3A_91C5, 50, 1'b0, "R6");
    send_frame(4'h6, 12'h4C2, 12'h9B1, 1'b0, 32'h0, 70, 1'b1, "R9");
    send_frame(4'hA, 12'h3E5, 12'h1D8, 1'b1, 32'h0123_4567, 100, 1'b1, "R9");

    // Random frames.
    for (int n = 0; n < 24; n++) begin
      send_frame(4'($urandom), 12'($urandom), 12'($urandom),
                 ($urandom_range(3) == 0), $urandom,
                 int'($urandom_range(100, 15)), ($urandom_range(5) == 0),
                 "R10");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R10: watchdog expired got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule